// File: doc/BRIEF.md
# Bounded-Repetition Handshake Sequence Monitor

This block is a synthesizable runtime checker for one handshake sequence. An attempt opens on a clock edge where the request input is high and the data bus reads zero. On the following edges the bus must hold a nonzero value for a run of three to five consecutive samples. The attempt then closes on the next edge, which must see the acknowledge input high with the bus back at zero. The monitor signals each completed attempt and each broken attempt with a one-cycle pulse. It also keeps a sticky error flag that only reset clears.

A fresh attempt may begin on any edge, including the same edge on which an earlier attempt resolves. The monitor therefore keeps a small pool of identical attempt trackers. A free tracker is claimed whenever the opening condition holds. Each tracker counts the nonzero samples it has seen, and it is released when its attempt matches or fails. Pulses appear on the cycle right after the deciding sample, because the outputs are registered.

Top module: `seq_rep_monitor`

## Requirements
- R1: While reset is high, and on the cycle after it, match_o, fail_o and err_o are 0 and no attempt is in flight.
- R2: An attempt opens only on an edge with req_i = 1 and data_i = 0. A request with a nonzero bus opens nothing and produces no later pulse.
- R3: After exactly 3 nonzero samples, a sample with ack_i = 1 and data_i = 0 is a match. match_o is 1 in the cycle after that edge.
- R4: A closing sample with ack_i = 1 and data_i = 0 after 4 or after 5 nonzero samples is also a match.
- R5: A zero sample after fewer than 3 nonzero samples is a failure, whatever ack_i is. fail_o is 1 in the cycle after that edge.
- R6: A zero sample with ack_i = 0 after 3 to 5 nonzero samples is a failure.
- R7: A sixth consecutive nonzero sample is a failure, reported on that sample.
- R8: err_o goes to 1 together with the first fail_o pulse and stays 1 until reset.
- R9: A closing sample that also satisfies the opening condition ends one attempt and opens another on the same edge. Both attempts are tracked.
- R10: ack_i high while the bus is nonzero counts as an ordinary nonzero sample and ends nothing.
- R11: match_o and fail_o are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request, part of the opening condition |
| ack_i | input | 1 | Acknowledge, part of the closing condition |
| data_i | input | DATA_W | Monitored data bus |
| match_o | output | 1 | Pulse: an attempt completed |
| fail_o | output | 1 | Pulse: an attempt broke |
| err_o | output | 1 | Sticky failure flag |

## Verification
The bench drives run lengths of two, three, five and six nonzero samples. An off-by-one in the run window would show up as a match in place of a fail at the two edges, or the reverse. It also drives a closing edge that reopens at once. A design that freed the tracker before claiming a new one would drop the second attempt and miss its later pulse. Requests with a nonzero bus, and acknowledges in the middle of a run, are mixed in. A design that opened or closed attempts on the wrong condition would emit stray pulses against the reference model. Biased random traffic then compares all three outputs against that model on every edge.

// File: rtl/seq_mon_pkg.sv
package seq_mon_pkg;
   typedef enum logic [1:0] {
      OUT_NONE = 2'd0,
      OUT_HIT  = 2'd1,
      OUT_MISS = 2'd2
   } seq_out_e;
endpackage

// File: rtl/seq_slot.sv
module seq_slot
   import seq_mon_pkg::*;
#(
   parameter int MIN_REP = 3,
   parameter int MAX_REP = 5,
   parameter int CNT_W   = 3
) (
   input  logic     clk_i,
   input  logic     rst_i,
   input  logic     start_i,
   input  logic     ack_i,
   input  logic     zero_i,
   output logic     busy_o,
   output seq_out_e outc_o
);
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      outc_o = OUT_NONE;
      if (busy_q) begin
         if (!zero_i) begin
            if (cnt_q == CNT_W'(MAX_REP)) outc_o = OUT_MISS;
         end else if (ack_i && cnt_q >= CNT_W'(MIN_REP)) begin
            outc_o = OUT_HIT;
         end else begin
            outc_o = OUT_MISS;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (outc_o != OUT_NONE) busy_q <= 1'b0;
         else                    cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign busy_o = busy_q;

   // R7: a run that is already full and sees another nonzero sample must fail
   a_r7_overrun_fails: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_q && cnt_q == CNT_W'(MAX_REP) && !zero_i) |-> (outc_o == OUT_MISS));
   // R2: the allocator hands out only idle trackers
   a_r2_start_on_idle: assert property (@(posedge clk_i) disable iff (rst_i)
      start_i |-> !busy_q);
   // R10: a nonzero sample below the run limit never resolves the attempt
   a_r10_nonzero_continues: assert property (@(posedge clk_i) disable iff (rst_i)
      (busy_q && !zero_i && cnt_q < CNT_W'(MAX_REP)) |=> busy_q);
endmodule

// File: rtl/slot_alloc.sv
module slot_alloc #(
   parameter int SLOTS = 7
) (
   input  logic [SLOTS-1:0] busy_i,
   input  logic             want_i,
   output logic [SLOTS-1:0] grant_o
);
   always_comb begin
      logic found;
      found   = 1'b0;
      grant_o = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (want_i && !found && !busy_i[i]) begin
            grant_o[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end

   a_r9_grant_onehot: assert final ($onehot0(grant_o));
endmodule

// File: rtl/seq_rep_monitor.sv
module seq_rep_monitor
   import seq_mon_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int MIN_REP = 3,
   parameter int MAX_REP = 5,
   parameter int SLOTS   = MAX_REP + 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              req_i,
   input  logic              ack_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              match_o,
   output logic              fail_o,
   output logic              err_o
);
   localparam int CNT_W = $clog2(MAX_REP + 1);

   generate
      if (MIN_REP < 1 || MAX_REP < MIN_REP) begin : g_bad_window
         $error("seq_rep_monitor: repetition window is invalid");
      end
      if (SLOTS < 2) begin : g_bad_slots
         $error("seq_rep_monitor: at least two trackers are required");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("seq_rep_monitor: data width must be positive");
      end
   endgenerate

   logic             zero;
   logic             open_now;
   logic [SLOTS-1:0] busy;
   logic [SLOTS-1:0] grant;
   logic [SLOTS-1:0] hit;
   logic [SLOTS-1:0] miss;
   logic             match_q, fail_q, err_q;

   assign zero     = (data_i == '0);
   assign open_now = req_i && zero;

   slot_alloc #(.SLOTS(SLOTS)) i_alloc (
      .busy_i  (busy),
      .want_i  (open_now),
      .grant_o (grant)
   );

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      seq_out_e outc;
      seq_slot #(
         .MIN_REP (MIN_REP),
         .MAX_REP (MAX_REP),
         .CNT_W   (CNT_W)
      ) i_slot (
         .clk_i   (clk_i),
         .rst_i   (rst_i),
         .start_i (grant[s]),
         .ack_i   (ack_i),
         .zero_i  (zero),
         .busy_o  (busy[s]),
         .outc_o  (outc)
      );
      assign hit[s]  = (outc == OUT_HIT);
      assign miss[s] = (outc == OUT_MISS);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         match_q <= 1'b0;
         fail_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         match_q <= |hit;
         fail_q  <= |miss;
         err_q   <= err_q | (|miss);
      end
   end

   assign match_o = match_q;
   assign fail_o  = fail_q;
   assign err_o   = err_q;

   // R1: outputs are quiet on the cycle after reset
   a_r1_reset_quiet: assert property (@(posedge clk_i)
      rst_i |=> (!match_o && !fail_o && !err_o));
   // R8: the error flag never drops without reset
   a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
      err_o |=> err_o);
   // R8: every failure pulse comes with the flag set
   a_r8_fail_sets_err: assert property (@(posedge clk_i) disable iff (rst_i)
      fail_o |-> err_o);
   // R11: pulses never coincide
   a_r11_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
      !(match_o && fail_o));
   // R9: an opening edge always finds a tracker, even if one resolves on that edge
   a_r9_open_granted: assert property (@(posedge clk_i) disable iff (rst_i)
      open_now |-> (grant != '0));
endmodule

// File: tb/test_seq_rep_monitor.sv
`timescale 1ns/1ps
module test_seq_rep_monitor;
   localparam int DW = 8;
   localparam int MINR = 3;
   localparam int MAXR = 5;

   logic clk = 1'b0;
   logic rst, req, ack;
   logic [DW-1:0] data;
   logic match_o, fail_o, err_o;

   int n_run = 0, n_fail = 0;
   int live[$];
   bit exp_m, exp_f, exp_e;

   always #2.5 clk = ~clk;

   seq_rep_monitor #(.DATA_W(DW), .MIN_REP(MINR), .MAX_REP(MAXR)) i_seq_rep_monitor (
      .clk_i(clk), .rst_i(rst), .req_i(req), .ack_i(ack), .data_i(data),
      .match_o(match_o), .fail_o(fail_o), .err_o(err_o)
   );

   task automatic chk(string tag, string what, bit act, bit exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
      end
   endtask

   // Reference model: a list of run counts, one per open attempt.
   task automatic model(bit r, bit q, bit a, logic [DW-1:0] d);
      int nxt[$];
      exp_m = 0; exp_f = 0;
      if (r) begin
         live = {}; exp_e = 0;
         return;
      end
      foreach (live[i]) begin
         if (d != 0) begin
            if (live[i] == MAXR) exp_f = 1;
            else nxt.push_back(live[i] + 1);
         end else if (a && live[i] >= MINR) exp_m = 1;
         else exp_f = 1;
      end
      if (q && d == 0) nxt.push_back(0);
      live = nxt;
      if (exp_f) exp_e = 1;
   endtask

   task automatic step(string tag, bit r, bit q, bit a, logic [DW-1:0] d);
      @(negedge clk);
      rst = r; req = q; ack = a; data = d;
      @(posedge clk);
      model(r, q, a, d);
      #1;
      chk(tag, "match_o", match_o, exp_m);
      chk(tag, "fail_o", fail_o, exp_f);
      chk(tag, "err_o", err_o, exp_e);
   endtask

   task automatic run(string tag, int n);
      for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 8'(i + 1));
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst = 1; req = 0; ack = 0; data = 0;
      step("R1", 1, 0, 0, 0);
      step("R1", 1, 1, 1, 0);
      step("R1", 0, 0, 0, 0);
      // R3: three nonzero, then close
      step("R3", 0, 1, 0, 0); run("R3", 3); step("R3", 0, 0, 1, 0);
      chk("R3", "match pulse", match_o, 1'b1);
      step("R11", 0, 0, 0, 0);
      chk("R11", "match one cycle", match_o, 1'b0);
      // R4: four and five
      step("R4", 0, 1, 0, 0); run("R4", 4); step("R4", 0, 0, 1, 0);
      chk("R4", "match after 4", match_o, 1'b1);
      step("R4", 0, 1, 0, 0); run("R4", 5); step("R4", 0, 0, 1, 0);
      chk("R4", "match after 5", match_o, 1'b1);
      chk("R8", "err still clear", err_o, 1'b0);
      // R2: request with nonzero bus opens nothing
      step("R2", 0, 1, 0, 8'h33); run("R2", 2); step("R2", 0, 0, 1, 0);
      chk("R2", "no match", match_o, 1'b0);
      chk("R2", "no fail", fail_o, 1'b0);
      // R10: ack in the middle of the run
      step("R10", 0, 1, 0, 0); step("R10", 0, 0, 1, 8'h5); run("R10", 2);
      step("R10", 0, 0, 1, 0);
      chk("R10", "match despite mid ack", match_o, 1'b1);
      // R9: close and reopen on one edge
      step("R9", 0, 1, 0, 0); run("R9", 3); step("R9", 0, 1, 1, 0);
      chk("R9", "first match", match_o, 1'b1);
      run("R9", 3); step("R9", 0, 0, 1, 0);
      chk("R9", "second match", match_o, 1'b1);
      // R5: short run
      step("R5", 0, 1, 0, 0); run("R5", 2); step("R5", 0, 0, 1, 0);
      chk("R5", "short run fails", fail_o, 1'b1);
      chk("R8", "err set", err_o, 1'b1);
      step("R11", 0, 0, 0, 0);
      chk("R11", "fail one cycle", fail_o, 1'b0);
      chk("R8", "err sticky", err_o, 1'b1);
      step("R1", 1, 0, 0, 0);
      chk("R1", "reset clears err", err_o, 1'b0);
      // R6: zero without ack
      step("R6", 0, 1, 0, 0); run("R6", 4); step("R6", 0, 0, 0, 0);
      chk("R6", "no ack fails", fail_o, 1'b1);
      // R7: sixth nonzero sample
      step("R7", 0, 1, 0, 0); run("R7", 6);
      chk("R7", "overrun fails", fail_o, 1'b1);
      step("R1", 1, 0, 0, 0);
      // Random traffic for R3 R4 R5 R6 R7 R9 R10, biased toward short runs
      for (int k = 0; k < 3000; k++) begin
         int p = $urandom_range(0, 9);
         step("R3_R7_random", 0, $urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0,
              (p < 3) ? 8'h00 : 8'($urandom_range(1, 255)));
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule